// File: doc/BRIEF.md
# Video Stream Field Filter

This block receives a serial byte stream of digital component video in which each line carries embedded timing reference codes. It recognises those codes, follows the stream's field and blanking structure, and forwards to its output only the words that the selected capture mode calls for. Samples can be 8 or 10 bits wide, chosen by one input. Nothing is forwarded until the stream has locked to the start of field 1.

A timing reference code is four words: the all-ones word, two all-zero words, then a status word. The status word carries a field flag F, a vertical blanking flag V and a code-kind flag H. Every word passes through a three-word holding pipe. This lets the preamble words of a code be stripped after the status word has shown that they form a code. Each forwarded word leaves the block once three more words have been accepted behind it, and words leave in the order they arrived.

The controller is a four-state machine. **HUNT** is the state after reset and means the block is not yet locked. **HBLANK** follows an end-of-active-video code with V=0. **ACTIVE** follows a start-of-active-video code with V=0. **VBLANK** follows any code with V=1. The transitions are:
- **lock**: HUNT to ACTIVE or HBLANK, taken at the field-1 start code.
- **sav**: to ACTIVE.
- **eav**: to HBLANK.
- **vblank_entry**: to VBLANK.

Once locked, every code moves the machine to the state named by its V and H flags.

Top module: `vid_field_filter`

## Requirements
- R1: After reset, `out_valid` and `locked` are 0.
- R2: A code is the word sequence ones, zero, zero, status. In 8-bit mode (`wide`=0) only `in_data[7:0]` is compared with 0xFF, 0x00, 0x00. The upper input bits are ignored, and forwarded words have their upper bits at zero. In 10-bit mode the full values 0x3FF, 0x000, 0x000 are compared. The status flags F, V, H sit in bits 6, 5, 4 in 8-bit mode and in bits 8, 7, 6 in 10-bit mode. H=0 marks start of active video and H=1 marks end of active video.
- R3: Lock occurs at the first code with F=0 and V=0 whose preceding code had V=1. `locked` rises on the beat of that status word and stays high until reset. No word is forwarded before lock.
- R4: `mode` selects the capture mode: 2'b00 active video, 2'b01 vertical blanking, 2'b10 entire field, 2'b11 discard everything.
- R5: In active-video mode, only words received after a start code with V=0 and before the next code are forwarded. Preamble and status words are never forwarded in this mode.
- R6: In active-video mode, only the first `line_limit` active lines of a frame are forwarded. The line count restarts at every code with F=0 whose V falls from 1 to 0.
- R7: In vertical-blanking mode, only non-code words received while the last code had V=1 are forwarded.
- R8: In entire-field mode, every word after the lock status word is forwarded, including preambles and status words.
- R9: Forwarded words keep their input order. `out_valid` is high only in the cycle after an accepted input beat.
- R10: Cycles with `in_valid`=0 have no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Capture mode select (see R4) |
| wide | input | 1 | 1 = 10-bit words, 0 = 8-bit words |
| line_limit | input | LINE_W | Active lines to forward per frame |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Input video word |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | DATA_W | Forwarded video word |
| locked | output | 1 | High once field-1 lock has occurred |

## Verification
The bench sweeps every mode in both word widths over a synthetic stream. The stream begins inside field 2, so it exercises the lock rule: a design that locked on the first V=0 code would forward field-2 words. In 10-bit runs, a 0x0FF, 0x000, 0x000 pattern is placed inside active video, which catches a detector that compares only 8 bits and would drop the rest of that line. The line limit is swept through 0, 2, 4 and 7. These values catch an off-by-one in the limit and a counter that fails to restart at the second frame, which would drop that frame's lines. Input gaps are inserted throughout, so a pipe that advanced without a valid beat would drop or repeat words.

// File: rtl/vfilt_pkg.sv
package vfilt_pkg;
    localparam int NARROW_W = 8;
    localparam int PRE_LEN  = 3;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'b00,
        MODE_VBLANK = 2'b01,
        MODE_ENTIRE = 2'b10,
        MODE_OFF    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HBLANK,
        ST_ACTIVE,
        ST_VBLANK
    } state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;
endpackage

// File: rtl/trs_match.sv
module trs_match
    import vfilt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                           wide,
    input  logic [DATA_W-1:0]              word,
    input  logic [PRE_LEN-1:0][DATA_W-1:0] taps,
    output logic                           hit,
    output trs_flags_t                     flags
);
    localparam logic [DATA_W-1:0] ONES_W = '1;
    localparam logic [DATA_W-1:0] ONES_N = DATA_W'((1 << NARROW_W) - 1);

    logic [DATA_W-1:0] ones;

    always_comb begin
        ones = wide ? ONES_W : ONES_N;
        hit  = (taps[PRE_LEN-1] == ones) && (taps[1] == '0) && (taps[0] == '0);
        if (wide) begin
            flags.f = word[DATA_W-2];
            flags.v = word[DATA_W-3];
            flags.h = word[DATA_W-4];
        end else begin
            flags.f = word[NARROW_W-2];
            flags.v = word[NARROW_W-3];
            flags.h = word[NARROW_W-4];
        end
    end
endmodule

// File: rtl/hold_pipe.sv
module hold_pipe
    import vfilt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [DATA_W-1:0]              in_word,
    input  logic                           in_keep,
    input  logic                           strip,
    output logic [PRE_LEN-1:0][DATA_W-1:0] taps,
    output logic                           out_valid,
    output logic [DATA_W-1:0]              out_data
);
    logic [PRE_LEN-1:0][DATA_W-1:0] word_q;
    logic [PRE_LEN-1:0]             keep_q;

    assign taps = word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            keep_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid) begin
            out_valid <= keep_q[PRE_LEN-1] & ~strip;
            out_data  <= word_q[PRE_LEN-1];
            word_q[0] <= in_word;
            keep_q[0] <= in_keep;
            for (int i = 1; i < PRE_LEN; i++) begin
                word_q[i] <= word_q[i-1];
                keep_q[i] <= keep_q[i-1] & ~strip;
            end
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/field_fsm.sv
module field_fsm
    import vfilt_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              hit,
    input  trs_flags_t        flags,
    input  mode_e             mode,
    input  logic [LINE_W-1:0] line_limit,
    output logic              in_keep,
    output logic              strip,
    output logic              locked
);
    state_e            state, state_nx;
    logic              prev_v;
    logic [LINE_W-1:0] line_cnt;
    logic              code_beat;
    logic              field1_start;
    state_e            code_target;

    always_comb begin
        code_beat    = in_valid && hit;
        field1_start = code_beat && !flags.f && !flags.v && prev_v;
        if (flags.v)      code_target = ST_VBLANK;
        else if (flags.h) code_target = ST_HBLANK;
        else              code_target = ST_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if (field1_start) state_nx = code_target;
            ST_HBLANK,
            ST_ACTIVE,
            ST_VBLANK: if (code_beat)    state_nx = code_target;
            default:   state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v   <= 1'b0;
            line_cnt <= '0;
        end else if (code_beat) begin
            prev_v <= flags.v;
            if (field1_start)
                line_cnt <= '0;
            else if (state == ST_ACTIVE && flags.h && line_cnt != '1)
                line_cnt <= line_cnt + 1'b1;
        end
    end

    always_comb begin
        locked  = (state != ST_HUNT);
        strip   = code_beat && (mode != MODE_ENTIRE);
        in_keep = 1'b0;
        if (hit) begin
            in_keep = (mode == MODE_ENTIRE) && locked;
        end else begin
            unique case (mode)
                MODE_ACTIVE: in_keep = (state == ST_ACTIVE) && (line_cnt < line_limit);
                MODE_VBLANK: in_keep = (state == ST_VBLANK);
                MODE_ENTIRE: in_keep = locked;
                MODE_OFF:    in_keep = 1'b0;
                default:     in_keep = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vid_field_filter.sv
module vid_field_filter
    import vfilt_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              wide,
    input  logic [LINE_W-1:0] line_limit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              locked
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0]              in_word;
    logic [PRE_LEN-1:0][DATA_W-1:0] taps;
    logic                           hit;
    trs_flags_t                     flags;
    logic                           in_keep;
    logic                           strip;
    mode_e                          mode_sel;

    assign in_word  = wide ? in_data : {{PAD_W{1'b0}}, in_data[NARROW_W-1:0]};
    assign mode_sel = mode_e'(mode);

    trs_match #(.DATA_W(DATA_W)) u_match (
        .wide  (wide),
        .word  (in_word),
        .taps  (taps),
        .hit   (hit),
        .flags (flags)
    );

    field_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .hit        (hit),
        .flags      (flags),
        .mode       (mode_sel),
        .line_limit (line_limit),
        .in_keep    (in_keep),
        .strip      (strip),
        .locked     (locked)
    );

    hold_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_keep   (in_keep),
        .strip     (strip),
        .taps      (taps),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/vfilt_checks.sv
module vfilt_checks (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic locked
);
    a_r3_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r3_no_out_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    a_r3_lock_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid));

    a_r9_out_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

bind vid_field_filter vfilt_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .locked    (locked)
);

// File: tb/tb_vid_field_filter.sv
`timescale 1ns/1ps
module tb_vid_field_filter;
    localparam int DW = 10;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          wide;
    logic [LW-1:0] line_limit;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          locked;

    always #2 clk = ~clk;

    vid_field_filter #(.DATA_W(DW), .LINE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wide(wide),
        .line_limit(line_limit), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .locked(locked)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int wid     = 0;
    string tag  = "R1";
    logic [DW-1:0] exp_q[$];

    // reference model state
    bit m_locked, m_prev_v, m_in_active, m_in_vblank;
    int m_act_idx, m_mode, m_lc;
    bit m_wide;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // R9 output order: compare every forwarded word with the model queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, tag, int'(out_data), -1);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(out_data == e, tag, int'(out_data), int'(e));
            end
        end
    end

    function automatic logic [DW-1:0] mask(input logic [DW-1:0] raw);
        return m_wide ? raw : (raw & 10'h0FF);
    endfunction

    // R10: idle gaps are inserted between beats
    task automatic send(input logic [DW-1:0] raw);
        in_valid = 1'b1;
        in_data  = raw;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        if (wid % 5 == 3) @(negedge clk);
        wid++;
    endtask

    task automatic emit(input logic [DW-1:0] raw, input bit pass);
        if (pass) exp_q.push_back(mask(raw));
        send(raw);
    endtask

    function automatic bit sample_pass();
        case (m_mode)
            0: return m_in_active && (m_act_idx < m_lc);
            1: return m_in_vblank;
            2: return m_locked;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [DW-1:0] mk_sample();
        if (m_wide) return DW'(10'h040 + (wid % 896));
        return {2'(wid), 8'(16 + wid % 224)};
    endfunction

    task automatic samples(input int n, input bit pass_en);
        for (int i = 0; i < n; i++) emit(mk_sample(), pass_en && sample_pass());
    endtask

    // R2: preamble with garbage upper bits in 8-bit mode
    task automatic code(input bit f, input bit v, input bit h);
        bit cpass, lock_now;
        logic [DW-1:0] st;
        cpass    = (m_mode == 2) && m_locked;
        lock_now = !m_locked && !f && !v && m_prev_v;
        emit(m_wide ? 10'h3FF : 10'h2FF, cpass);
        emit(m_wide ? 10'h000 : 10'h200, cpass);
        emit(m_wide ? 10'h000 : 10'h100, cpass);
        st = m_wide ? {1'b1, f, v, h, 6'b0} : {2'b11, 1'b1, f, v, h, 4'b0};
        if (lock_now) check(locked == 1'b0, "R3", int'(locked), 0);
        emit(st, cpass);
        if (lock_now) begin
            m_locked = 1'b1;
            check(locked == 1'b1, "R3", int'(locked), 1);
        end
        if (!f && !v && m_prev_v) m_act_idx = 0;
        else if (h && m_in_active) m_act_idx++;
        m_in_active = m_locked && !v && !h;
        m_in_vblank = m_locked && v;
        m_prev_v    = v;
    endtask

    task automatic line(input bit f, input bit v, input bit inject);
        code(f, v, 1'b1);
        samples(4, 1'b1);
        code(f, v, 1'b0);
        samples(6, 1'b1);
        // R2: a pattern that is a code only in 8-bit form must pass as data
        if (inject && m_wide && m_in_active) begin
            bit p;
            p = sample_pass();
            emit(10'h0FF, p);
            emit(10'h000, p);
            emit(10'h000, p);
            emit(10'h2C0, p);
            samples(3, 1'b1);
        end
    endtask

    task automatic run(input int md, input bit wd, input int lc, input string t);
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        mode = 2'(md); wide = wd; line_limit = LW'(lc);
        m_mode = md; m_wide = wd; m_lc = lc;
        m_locked = 0; m_prev_v = 0; m_in_active = 0; m_in_vblank = 0; m_act_idx = 0;
        exp_q.delete();
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && locked == 1'b0, "R1", int'({out_valid, locked}), 0);
        tag = t;
        samples(3, 1'b1);
        line(1, 0, 0); line(1, 1, 0); line(0, 1, 0); line(0, 1, 0);
        line(0, 0, 0); line(0, 0, 1); line(0, 0, 0);
        line(0, 1, 0); line(1, 1, 0);
        line(1, 0, 0); line(1, 0, 0); line(1, 0, 0);
        line(1, 1, 0); line(0, 1, 0);
        line(0, 0, 0); line(0, 0, 0);
        code(0, 1, 1);
        samples(3, 1'b0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, t, exp_q.size(), 0);
    endtask

    bit finished = 0;

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        mode = '0; wide = 1'b1; line_limit = '0;
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            run(0, w[0], 0, "R5 R6 R4 R2");
            run(0, w[0], 2, "R5 R6 R2");
            run(0, w[0], 4, "R5 R6 R2");
            run(0, w[0], 7, "R5 R6 R2");
            run(1, w[0], 0, "R7 R4 R2");
            run(2, w[0], 0, "R8 R4 R2");
            run(3, w[0], 0, "R4 R2");
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule